// File: doc/BRIEF.md
# Selectable-Source Timer Prescaler

This block divides a chosen event source by a programmable ratio and emits a one-cycle tick that a group of three timers can share as their slow time base. The source is either a strobe at half the system clock rate or the rising edges of one of three external timer pins. Each external pin is brought into the system clock domain through a two-flop synchronizer and an edge detector. Every part of the block runs on the single system clock; the half-rate source is an enable strobe, not a derived clock.

A 24-bit configuration word holds a 21-bit preload count and a 2-bit source selector; its top bit reads as zero. The prescaler runs whenever any of the three timer enables is high. A down-counter is loaded with the preload when the prescaler becomes enabled. It then steps once per source event, and on the event that finds it at zero it reloads and raises the tick. A preload of N gives one tick per N+1 source events.

Top module: `tick_prescaler`

## Requirements
- R1: After reset the configuration word reads as 0 and the tick output is low.
- R2: A write stores bits 20..0 as the preload and bits 22..21 as the source selector; the read value is {1'b0, selector, preload}, so bit 23 reads 0 whatever was written there.
- R3: With selector 00, a source event occurs every second system clock while enabled, so ticks repeat every 2*(N+1) cycles for preload N.
- R4: Selector 01, 10 and 11 choose external pin 0, 1 and 2; each rising edge of the chosen pin, after two synchronizing flops, is one source event, so ticks repeat every N+1 pin periods.
- R5: Edges on the pins that are not selected produce no ticks.
- R6: The tick is high for exactly one system clock and reloads the counter with the preload.
- R7: A preload of 0 gives a tick on every source event.
- R8: While all three timer enables are low, no tick is produced and the counter holds its value.
- R9: On the transition from disabled to enabled the counter is loaded with the preload, so the first tick comes after N+1 events however far a previous run had counted; with selector 00 it appears 2*N cycles after the enabling clock edge.
- R10: Any single timer enable high is enough to run the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 24 | Configuration write data |
| cfg_rdata | output | 24 | Configuration read value |
| tmr_en | input | 3 | Enables of the three timers sharing the prescaler |
| ext_pin | input | 3 | External timer pins, asynchronous |
| tick | output | 1 | One-cycle prescaler tick |

## Verification
The assertions assume the external pins change no faster than once every two system clocks, so a synchronized edge never follows another in the next cycle, and that the selector is only rewritten while every timer enable is low. The bench keeps within this by driving the pins with an eight-cycle square wave and by clearing all enables before each reconfiguration. The single-cycle tick check also relies on every source producing at most one event per two clocks, which both source kinds do under those conditions.

// File: rtl/presc_pkg.sv
package presc_pkg;

  localparam int PL_W   = 21;
  localparam int SEL_W  = 2;
  localparam int REG_W  = 24;
  localparam int N_EXT  = 3;
  localparam int N_TMR  = 3;
  localparam int SYNC_N = 2;
  localparam int PAD_W  = REG_W - PL_W - SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SRC_HALF = 2'b00,
    SRC_PIN0 = 2'b01,
    SRC_PIN1 = 2'b10,
    SRC_PIN2 = 2'b11
  } src_e;

  // Read image of the configuration word: pad bits always zero.
  function automatic logic [REG_W-1:0] cfg_image(input logic [SEL_W-1:0] sel,
                                                 input logic [PL_W-1:0]  pl);
    return {{PAD_W{1'b0}}, sel, pl};
  endfunction

  // Source event selection: code 0 is the half-rate strobe, code k the pin k-1.
  function automatic logic pick_event(input logic [SEL_W-1:0] sel,
                                      input logic             half,
                                      input logic [N_EXT-1:0] rise);
    int idx;
    idx = int'(sel) - 1;
    if (sel == SRC_HALF) return half;
    return rise[idx];
  endfunction

  // Down-count with wrap to the preload.
  function automatic logic [PL_W-1:0] count_next(input logic [PL_W-1:0] cnt,
                                                 input logic [PL_W-1:0] pl);
    return (cnt == '0) ? pl : cnt - 1'b1;
  endfunction

endpackage

// File: rtl/presc_edge_sync.sv
module presc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[LAST-1:0], pin};
  end

  assign rise = shreg[LAST-1] & ~shreg[LAST];

  // R4: a synchronized edge lasts one cycle (pins slower than clk/2)
  a_r4_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/presc_src_sel.sv
module presc_src_sel
  import presc_pkg::*;
#(
  parameter int NPIN  = N_EXT,
  parameter int SYNCS = SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel,
  input  logic [NPIN-1:0]  ext_pin,
  output logic             src_ev,
  output logic             half_stb,
  output logic [NPIN-1:0]  pin_rise
);

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_sync
      presc_edge_sync #(.STAGES(SYNCS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin[g]),
        .rise (pin_rise[g])
      );
    end
  endgenerate

  // Half-rate strobe: toggles while enabled, parked low while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      half_stb <= 1'b0;
    else if (enable) half_stb <= ~half_stb;
    else             half_stb <= 1'b0;
  end

  assign src_ev = pick_event(sel, half_stb, pin_rise);

  // R3: the internal strobe alternates
  a_r3_half_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    half_stb |=> !half_stb);
  // R8: strobe parked while idle
  a_r8_half_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !half_stb);

endmodule

// File: rtl/presc_counter.sv
module presc_counter
  import presc_pkg::*;
#(
  parameter int W = PL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         src_ev,
  input  logic [W-1:0] preload,
  output logic         tick,
  output logic         start,
  output logic         run
);

  logic         en_q;
  logic [W-1:0] cnt;

  assign start = enable & ~en_q;
  assign run   = enable & en_q;
  assign tick  = run & src_ev & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cnt  <= '0;
    end else begin
      en_q <= enable;
      if (start)              cnt <= preload;
      else if (run && src_ev) cnt <= count_next(cnt, preload);
    end
  end

  // R9: enabling loads the preload
  a_r9_load_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == $past(preload));
  // R6: a tick reloads and is never two cycles wide
  a_r6_tick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(preload));
  a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R8: no tick and no counting while idle
  a_r8_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !tick);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || (run && !src_ev)) |=> $stable(cnt) || $past(start) == 1'b0 && start == 1'b0 && cnt == $past(cnt));

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import presc_pkg::*;
#(
  parameter int PLW  = PL_W,
  parameter int SW   = SEL_W,
  parameter int RW   = REG_W,
  parameter int NPIN = N_EXT,
  parameter int NTMR = N_TMR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [RW-1:0]   cfg_wdata,
  output logic [RW-1:0]   cfg_rdata,
  input  logic [NTMR-1:0] tmr_en,
  input  logic [NPIN-1:0] ext_pin,
  output logic            tick
);

  localparam int SEL_LO = PLW;
  localparam int SEL_HI = PLW + SW - 1;

  logic [PLW-1:0]  preload_q;
  logic [SW-1:0]   sel_q;
  logic            enable;
  logic            src_ev;
  logic            half_stb;
  logic [NPIN-1:0] pin_rise;
  logic            start;
  logic            run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_q <= '0;
      sel_q     <= '0;
    end else if (cfg_we) begin
      preload_q <= cfg_wdata[PLW-1:0];
      sel_q     <= cfg_wdata[SEL_HI:SEL_LO];
    end
  end

  assign cfg_rdata = cfg_image(sel_q, preload_q);
  assign enable    = |tmr_en;

  presc_src_sel #(.NPIN(NPIN), .SYNCS(SYNC_N)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .sel     (sel_q),
    .ext_pin (ext_pin),
    .src_ev  (src_ev),
    .half_stb(half_stb),
    .pin_rise(pin_rise)
  );

  presc_counter #(.W(PLW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .src_ev (src_ev),
    .preload(preload_q),
    .tick   (tick),
    .start  (start),
    .run    (run)
  );

  // R2: write data comes back on the read port
  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[SEL_HI:0] == $past(cfg_wdata[SEL_HI:0]));
  // R2: the pad bit of the read image stays clear after any write
  a_r2_pad_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[RW-1] == 1'b0);
  // R10: any timer enable starts or keeps the prescaler running
  a_r10_any_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en != '0) |-> (start || run));

endmodule

// File: tb/tick_prescaler_tb.sv
module tick_prescaler_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [23:0] cfg_wdata = '0;
  logic [23:0] cfg_rdata;
  logic [2:0]  tmr_en = '0;
  logic [2:0]  ext_pin = '0;
  logic        tick;
  logic [2:0]  drv_mask = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tmr_en(tmr_en), .ext_pin(ext_pin), .tick(tick)
  );

  // Pin driver: eight-cycle square wave on every pin in drv_mask.
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      for (int i = 0; i < 3; i++) ext_pin[i] = drv_mask[i] ? ((ph % 8) < 4) : 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tick) c++;
    end
  endtask

  task automatic wait_tick(input int limit, output int idx);
    idx = -1;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (tick) begin idx = k; break; end
    end
  endtask

  // Gap between two ticks, plus width check on the first.
  task automatic gap_test(input int exp_gap, input string tag);
    int idx, gap;
    bit low_after;
    wait_tick(4 * exp_gap + 40, idx);
    check(idx >= 0, {tag, " first tick seen"}, idx, 0);
    gap = 0; low_after = 1'b0;
    for (int k = 1; k <= 4 * exp_gap + 40; k++) begin
      @(negedge clk);
      if (k == 1) low_after = !tick;
      if (tick) begin gap = k; break; end
    end
    check(low_after, "R6 tick one cycle wide", !low_after, 0);
    check(gap == exp_gap, tag, gap, exp_gap);
  endtask

  task automatic t_reset;
    check(cfg_rdata == 24'h0, "R1 config reads zero", cfg_rdata, 0);
    check(tick == 1'b0, "R1 tick low", tick, 0);
  endtask

  task automatic t_regs;
    cfg_write(24'hFFFFFF);
    check(cfg_rdata == 24'h7FFFFF, "R2 bit 23 reads zero", cfg_rdata, 24'h7FFFFF);
    cfg_write(24'h8A5A5A);
    check(cfg_rdata == 24'h0A5A5A, "R2 fields stored", cfg_rdata, 24'h0A5A5A);
    cfg_write(24'h000000);
  endtask

  task automatic t_idle;
    int c;
    cfg_write({1'b0, 2'b00, 21'd2});
    tmr_en = 3'b000;
    count_ticks(60, c);
    check(c == 0, "R8 no ticks while disabled", c, 0);
  endtask

  task automatic t_half;
    cfg_write({1'b0, 2'b00, 21'd3});
    @(negedge clk); tmr_en = 3'b001;
    gap_test(8, "R3 half-rate gap N=3");
    @(negedge clk); tmr_en = 3'b000;
    cfg_write({1'b0, 2'b00, 21'd0});
    @(negedge clk); tmr_en = 3'b010;
    gap_test(2, "R7 preload 0 half-rate gap");
    @(negedge clk); tmr_en = 3'b000;
  endtask

  task automatic t_reload;
    int idx;
    cfg_write({1'b0, 2'b00, 21'd5});
    @(negedge clk); tmr_en = 3'b001;
    wait_tick(40, idx);
    check(idx == 10, "R9 first tick latency", idx, 10);
    repeat (3) @(negedge clk);
    tmr_en = 3'b000;
    repeat (5) @(negedge clk);
    tmr_en = 3'b100;
    wait_tick(40, idx);
    check(idx == 10, "R9 R10 reload on re-enable", idx, 10);
    @(negedge clk); tmr_en = 3'b000;
  endtask

  task automatic t_ext;
    cfg_write({1'b0, 2'b01, 21'd2});
    drv_mask = 3'b001;
    @(negedge clk); tmr_en = 3'b001;
    gap_test(24, "R4 pin0 gap N=2");
    @(negedge clk); tmr_en = 3'b000; drv_mask = 3'b000;
    cfg_write({1'b0, 2'b11, 21'd1});
    drv_mask = 3'b100;
    @(negedge clk); tmr_en = 3'b001;
    gap_test(16, "R4 pin2 gap N=1");
    @(negedge clk); tmr_en = 3'b000; drv_mask = 3'b000;
    cfg_write({1'b0, 2'b10, 21'd0});
    drv_mask = 3'b010;
    @(negedge clk); tmr_en = 3'b001;
    gap_test(8, "R7 R4 pin1 gap N=0");
    @(negedge clk); tmr_en = 3'b000; drv_mask = 3'b000;
  endtask

  task automatic t_unselected;
    int c;
    cfg_write({1'b0, 2'b01, 21'd0});
    drv_mask = 3'b110;
    @(negedge clk); tmr_en = 3'b011;
    count_ticks(100, c);
    check(c == 0, "R5 unselected pins ignored", c, 0);
    @(negedge clk); tmr_en = 3'b000; drv_mask = 3'b000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_idle;
    t_half;
    t_reload;
    t_ext;
    t_unselected;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule